// File: doc/BRIEF.md
# Two-Mode Memory Map Decoder

This block decodes addresses for an 8-bit processor with a 16-bit address bus that runs code in two modes, privileged and unprivileged. A 4-bit configuration register selects the mode and a bank. The block turns that register and the CPU address into one-hot chip selects and into the two upper address lines of the unprivileged RAM. It also produces memory strobes that are gated by the PHI2 clock phase.

In privileged mode the map is fixed: boot ROM at the top, the configuration register page, three peripheral pages, a 16K window onto unprivileged RAM, and private RAM at the bottom. In unprivileged mode every address selects unprivileged RAM and nothing else is visible. A single register write enters unprivileged mode. An interrupt acknowledge or a reset returns the block to privileged mode.

Top module: `dual_mode_addr_map`

## Requirements
- R1: The asynchronous active-low reset `rst_n` clears the 4-bit configuration register to 0, which is privileged mode with bank 0.
- R2: In privileged mode, `rom_cs` is asserted for addresses 0xC000-0xFFFF and `priv_ram_cs` is asserted for 0x0000-0x3FFF.
- R3: In privileged mode, `cfg_cs` is asserted for 0xB000-0xBFFF. `dev_cs[2]` is asserted for 0xA000-0xAFFF, `dev_cs[1]` for 0x9000-0x9FFF and `dev_cs[0]` for 0x8000-0x8FFF.
- R4: In privileged mode, 0x4000-0x7FFF asserts `user_ram_cs`. In privileged mode, `user_ram_hi` always equals register bits 1:0 (the bank).
- R5: While register bit 3 is 1 (unprivileged mode), every address asserts `user_ram_cs` only, and `user_ram_hi` equals `cpu_addr[15:14]`.
- R6: When `irq_ack` is high at a rising clock edge, the register clears to 0. This takes priority over a register write in the same cycle.
- R7: The register loads `cpu_wdata[3:0]` at a rising edge only when all of these hold: privileged mode, an address in 0xB000-0xBFFF, `cpu_rw_n`=0 and `phi2`=1. The new mode or bank applies from the next cycle. Any other write leaves the register unchanged.
- R8: Register bit 2 is stored and read back, but it has no effect on any select or on `user_ram_hi`.
- R9: A read (`cpu_rw_n`=1) while `cfg_cs` is high returns the register on `cpu_rdata[3:0]` and zeros on bits 7:4. At all other times `cpu_rdata` is 0.
- R10: `mem_oe` = `phi2` AND read AND (`rom_cs` OR `priv_ram_cs` OR `user_ram_cs`). `mem_we` = `phi2` AND write AND (`priv_ram_cs` OR `user_ram_cs`).
- R11: Exactly one of the seven chip selects (`rom_cs`, `priv_ram_cs`, `user_ram_cs`, `cfg_cs`, `dev_cs[2:0]`) is high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the register updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_ack | input | 1 | Interrupt acknowledge; clears the register synchronously |
| phi2 | input | 1 | CPU clock phase 2 level; gates all strobes |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register readback data, zero when not selected |
| rom_cs | output | 1 | Boot ROM select |
| priv_ram_cs | output | 1 | Privileged RAM select |
| user_ram_cs | output | 1 | Unprivileged RAM select |
| cfg_cs | output | 1 | Configuration register page select |
| dev_cs | output | 3 | Peripheral page selects |
| user_ram_hi | output | 2 | Upper address lines A15:A14 of the unprivileged RAM |
| mem_oe | output | 1 | Memory output enable |
| mem_we | output | 1 | Memory write enable |

## Verification
A wrong register value shows at the ports in the cycle right after the faulty update. A bad bank makes `user_ram_hi` wrong for every privileged address. A bad mode bit moves every select to a different region. The readback at 0xB000 shows all four stored bits during the very next read. The address sweeps run once for every bank and reserved-bit combination, so a decode error confined to a single page or a single register value still shows up as a wrong select.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CFG_W  = 4;
    localparam int BANK_W = 2;
    localparam int NUM_DEV = 3;

    // page number (address bits 15:12) of the first peripheral page
    localparam logic [3:0] DEV_BASE_PAGE = 4'h8;
    localparam logic [3:0] CFG_PAGE      = 4'hB;

    typedef struct packed {
        logic              user;   // bit 3: unprivileged mode
        logic              rsvd;   // bit 2: stored only
        logic [BANK_W-1:0] bank;   // bits 1:0: window bank
    } cfg_t;

    typedef struct packed {
        logic               rom;
        logic               priv_ram;
        logic               user_ram;
        logic               cfg;
        logic [NUM_DEV-1:0] dev;
    } sel_t;

endpackage

// File: rtl/cfg_register.sv
module cfg_register
    import dmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_ack,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_val,
    output cfg_t             cfg
);

    typedef struct packed {
        cfg_t value;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_ack) begin
            st_d.value = '0;
        end else if (wr_en) begin
            st_d.value = cfg_t'(wr_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.value;

    // an acknowledged interrupt always lands in privileged mode, bank 0
    assert_irq_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (cfg == '0));

    // a qualified write without interrupt loads exactly the written bits
    assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !irq_ack) |=> (cfg == cfg_t'($past(wr_val))));

    // without any strobe the register holds
    assert_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !irq_ack) |=> $stable(cfg));

endmodule

// File: rtl/addr_decode.sv
module addr_decode
    import dmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    output sel_t              sel,
    output logic [BANK_W-1:0] ram_hi
);

    localparam int PAGE_LSB = ADDR_W - 4;
    localparam int HI_LSB   = ADDR_W - BANK_W;

    logic [3:0]         page;
    logic [BANK_W-1:0]  quarter;
    logic [NUM_DEV-1:0] dev_hit;

    assign page    = addr[ADDR_W-1:PAGE_LSB];
    assign quarter = addr[ADDR_W-1:HI_LSB];

    // one decoder per peripheral page, consecutive from the base page
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        localparam logic [3:0] PG = DEV_BASE_PAGE + 4'(g);
        assign dev_hit[g] = (page == PG);
    end

    always_comb begin
        sel    = '0;
        ram_hi = cfg.bank;
        if (cfg.user) begin
            sel.user_ram = 1'b1;
            ram_hi       = quarter;
        end else begin
            unique case (quarter)
                2'b11: sel.rom      = 1'b1;
                2'b01: sel.user_ram = 1'b1;
                2'b00: sel.priv_ram = 1'b1;
                2'b10: begin
                    if (page == CFG_PAGE) sel.cfg = 1'b1;
                    else                  sel.dev = dev_hit;
                end
                default: sel.priv_ram = 1'b1;
            endcase
        end
    end

    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);

    assert_user_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.user |-> (sel.user_ram && ram_hi == addr[ADDR_W-1:HI_LSB]));

    assert_window_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.user && addr[ADDR_W-1:HI_LSB] == 2'b01) |-> (sel.user_ram && ram_hi == cfg.bank));

    assert_rom_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.user && addr[ADDR_W-1:HI_LSB] == 2'b11) |-> sel.rom);

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import dmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              rw_n,
    input  sel_t              sel,
    input  cfg_t              cfg,
    output logic              cfg_wr,
    output logic              mem_oe,
    output logic              mem_we,
    output logic [DATA_W-1:0] rdata
);

    logic any_mem;
    logic any_ram;

    assign any_mem = sel.rom | sel.priv_ram | sel.user_ram;
    assign any_ram = sel.priv_ram | sel.user_ram;

    always_comb begin
        cfg_wr = phi2 & ~rw_n & sel.cfg;
        mem_oe = phi2 & rw_n & any_mem;
        mem_we = phi2 & ~rw_n & any_ram;
        rdata  = '0;
        if (sel.cfg && rw_n) begin
            rdata[CFG_W-1:0] = cfg;
        end
    end

    assert_we_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_oe || cfg_wr) |-> phi2);

    assert_no_rom_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel.rom |-> !mem_we);

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel.cfg && rw_n) |-> (rdata == '0));

endmodule

// File: rtl/dual_mode_addr_map.sv
module dual_mode_addr_map
    import dmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_ack,
    input  logic              phi2,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rw_n,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              rom_cs,
    output logic              priv_ram_cs,
    output logic              user_ram_cs,
    output logic              cfg_cs,
    output logic [2:0]        dev_cs,
    output logic [1:0]        user_ram_hi,
    output logic              mem_oe,
    output logic              mem_we
);

    cfg_t cfg;
    sel_t sel;
    logic cfg_wr;

    cfg_register u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_ack (irq_ack),
        .wr_en   (cfg_wr),
        .wr_val  (cpu_wdata[CFG_W-1:0]),
        .cfg     (cfg)
    );

    addr_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (cpu_addr),
        .cfg    (cfg),
        .sel    (sel),
        .ram_hi (user_ram_hi)
    );

    strobe_gen u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .phi2   (phi2),
        .rw_n   (cpu_rw_n),
        .sel    (sel),
        .cfg    (cfg),
        .cfg_wr (cfg_wr),
        .mem_oe (mem_oe),
        .mem_we (mem_we),
        .rdata  (cpu_rdata)
    );

    assign rom_cs      = sel.rom;
    assign priv_ram_cs = sel.priv_ram;
    assign user_ram_cs = sel.user_ram;
    assign cfg_cs      = sel.cfg;
    assign dev_cs      = sel.dev;

    // once in unprivileged mode, only an interrupt leaves it
    assert_user_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.user && !irq_ack) |=> cfg.user);

endmodule

// File: tb/sim_dual_mode_addr_map.sv
module sim_dual_mode_addr_map;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_ack = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw_n = 1'b1;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        rom_cs, priv_ram_cs, user_ram_cs, cfg_cs;
    logic [2:0]  dev_cs;
    logic [1:0]  user_ram_hi;
    logic        mem_oe, mem_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mode_addr_map u0 (
        .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .phi2(phi2),
        .cpu_addr(cpu_addr), .cpu_rw_n(cpu_rw_n), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .rom_cs(rom_cs), .priv_ram_cs(priv_ram_cs),
        .user_ram_cs(user_ram_cs), .cfg_cs(cfg_cs), .dev_cs(dev_cs),
        .user_ram_hi(user_ram_hi), .mem_oe(mem_oe), .mem_we(mem_we)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h)", req, act, exp, cpu_addr);
        end
    endtask

    // expected selects as {rom, priv_ram, user_ram, cfg, dev[2:0]}
    function automatic logic [6:0] exp_sel(input logic [15:0] a, input logic [3:0] r);
        if (r[3]) return 7'b0010000;
        if (a >= 16'hC000) return 7'b1000000;
        if (a >= 16'hB000) return 7'b0001000;
        if (a >= 16'hA000) return 7'b0000100;
        if (a >= 16'h9000) return 7'b0000010;
        if (a >= 16'h8000) return 7'b0000001;
        if (a >= 16'h4000) return 7'b0010000;
        return 7'b0100000;
    endfunction

    task automatic check_vector(input logic [3:0] r);
        logic [6:0] es;
        logic [6:0] as;
        logic [1:0] ehi;
        logic [7:0] erd;
        logic       emem, eram;
        es   = exp_sel(cpu_addr, r);
        as   = {rom_cs, priv_ram_cs, user_ram_cs, cfg_cs, dev_cs};
        ehi  = r[3] ? cpu_addr[15:14] : r[1:0];
        erd  = (es[3] && cpu_rw_n) ? {4'h0, r} : 8'h00;
        emem = es[6] | es[5] | es[4];
        eram = es[5] | es[4];
        check(r[3] ? "R5 sel" : "R2/R3/R4 sel", as, es);
        check("R11 one-hot", $countones(as), 1);
        check(r[3] ? "R5 hi" : "R4 hi", user_ram_hi, ehi);
        check("R9 rdata", cpu_rdata, erd);
        check("R10 oe", mem_oe, phi2 & cpu_rw_n & emem);
        check("R10 we", mem_we, phi2 & ~cpu_rw_n & eram);
    endtask

    // drive one bus cycle across a rising edge, then idle
    task automatic bus_write(input logic [15:0] a, input logic [7:0] v, input logic ph);
        @(negedge clk);
        cpu_addr = a; cpu_rw_n = 1'b0; phi2 = ph; cpu_wdata = v;
        @(negedge clk);
        cpu_rw_n = 1'b1; phi2 = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00;
    endtask

    task automatic read_cfg(input string req, input logic [3:0] exp);
        @(negedge clk);
        cpu_addr = 16'hB123; cpu_rw_n = 1'b1; phi2 = 1'b1;
        #1;
        check(req, cpu_rdata, {4'h0, exp});
        phi2 = 1'b0;
    endtask

    task automatic sweep(input logic [3:0] r);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            cpu_addr = 16'(i * 128) + 16'(i % 97);
            phi2     = i[0];
            cpu_rw_n = i[1] | (!r[3] && cpu_addr[15:12] == 4'hB);
            cpu_wdata = 8'hFF;
            #1;
            check_vector(r);
        end
        @(negedge clk);
        cpu_rw_n = 1'b1; phi2 = 1'b0; cpu_addr = 16'h0000;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cpu_addr = 16'hB000; cpu_rw_n = 1'b1;
        #(CLK_PERIOD * 2 + 1ns);
        check("R1 reset rdata", cpu_rdata, 0);
        check("R1 reset cfg_cs", cfg_cs, 1);
        @(negedge clk);
        rst_n = 1'b1;
        read_cfg("R1 after reset", 4'h0);

        // privileged sweeps over every bank and reserved-bit value (R2 R3 R4 R8 R9 R10 R11)
        for (int r = 0; r < 8; r++) begin
            bus_write(16'hB000 + 16'(r * 16'h111), {4'hA, 4'(r)}, 1'b1);
            read_cfg("R9 readback", 4'(r));
            sweep(4'(r));
        end

        // R7: writes that must not load
        bus_write(16'hB000, 8'h03, 1'b1);
        bus_write(16'hB400, 8'h0C, 1'b0);
        read_cfg("R7 phi2 low ignored", 4'h3);
        bus_write(16'h1000, 8'h0E, 1'b1);
        read_cfg("R7 other address ignored", 4'h3);
        bus_write(16'h9000, 8'h0E, 1'b1);
        read_cfg("R7 device page ignored", 4'h3);

        // R6: interrupt clears; wins over a simultaneous write
        bus_write(16'hB000, 8'h06, 1'b1);
        read_cfg("R7 load", 4'h6);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        read_cfg("R6 clear", 4'h0);
        @(negedge clk);
        cpu_addr = 16'hB000; cpu_rw_n = 1'b0; phi2 = 1'b1; cpu_wdata = 8'h0B; irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; cpu_rw_n = 1'b1; phi2 = 1'b0;
        read_cfg("R6 priority over write", 4'h0);

        // R5/R7: enter unprivileged mode; decode changes only after the edge
        @(negedge clk);
        cpu_addr = 16'hB000; cpu_rw_n = 1'b0; phi2 = 1'b1; cpu_wdata = 8'hF9;
        #1;
        check("R7 same cycle still privileged", cfg_cs, 1);
        @(negedge clk);
        #1;
        check("R5 next cycle user", user_ram_cs, 1);
        cpu_rw_n = 1'b1; phi2 = 1'b0;
        sweep(4'h9);
        bus_write(16'hB000, 8'h00, 1'b1);
        #1;
        cpu_addr = 16'hB000;
        #1;
        check("R5 register page hidden", cfg_cs, 0);
        sweep(4'h9);

        // R6: interrupt returns to privileged mode
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        read_cfg("R6 leave user mode", 4'h0);
        sweep(4'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule